// File: doc/BRIEF.md
# Serial Control Slave for an Infrared Transceiver

This block sits on the transceiver side of a three-wire control bus. One wire is a serial clock. A second wire carries transmit data in normal operation and write commands during a control transaction. The third wire carries receive pulses in normal operation and read responses during a transaction. The controller starts a transaction with a single clock edge. The slave then blocks the LED at once, so that command bits on the shared line never light it. It deserializes a command of two or three bytes, updates one of three 8-bit configuration registers or returns a byte on the receive line, and hands both lines back to infrared traffic when the transaction ends.

The serial clock is oversampled by the system clock `clk_i`, and all inputs are taken to be synchronous to it. Edges are counted only after an arming sequence. Outside a transaction, the configuration registers gate the transmit and receive paths and drive the shutdown, rate and power outputs.

Top module: `stc_slave`

## Requirements
- R1: After reset the slave ignores transactions until it has seen 30 consecutive serial-clock rising edges with the write line low. An edge with the write line high restarts this count. The arming edges themselves never start a transaction.
- R2: Once armed, an idle slave treats the next rising edge as a pending marker: `led_dis_o` rises and `led_o` stays low whatever the write line does. The edge after that is the start cycle of the first byte.
- R3: Each byte follows one start cycle and is sampled on rising edges, LSB first, with no gap between bytes. In the first byte, bits [2:0] hold the device address, bits [6:3] the index and bit 7 the direction (1 write, 0 read).
- R4: A write to index 0, 1 or 2 at address 000 stores the second byte in that register. `led_dis_o` falls on the edge that samples the last data bit.
- R5: Index 1111 makes the second byte an extended index. For a write, a third byte carries the data and the write is dropped. A read of extended index 0x00 returns 0x01, a read of 0x01 returns 0x41, and any other extended index returns 0x00.
- R6: For a read, the first edge after the command is a turnaround and the second is a start cycle. Response bits 0 to 7 are launched on `rxd_o` on the 3rd to 10th edges. `rxd_o` is high on every other edge. `rx_dis_o` is high for the whole response phase.
- R7: A read ends only on an edge that samples the write line low directly after an edge in the response phase that sampled it high. `led_dis_o` falls on that edge. Extra low edges keep the transaction open.
- R8: Reset leaves register 0 at 0x00 (shutdown, receive off, transmit off), register 1 at 0x00 (slow rate) and register 2 at 0xC0 (full power). So `shutdown_o`=1, `mir_o`=0 and `power_o`=3.
- R9: In register 0, bit 0 set means normal mode, bit 1 enables receive and bit 2 enables transmit. Idle in normal mode, `led_o` follows `swdat_i` if transmit is enabled, and `rxd_o` is the inverse of `rx_light_i` if receive is enabled. In shutdown, `led_o` is low and `rxd_o` is high.
- R10: Bit 0 of register 1 drives `mir_o`, and bits [7:6] of register 2 drive `power_o`.
- R11: A command with an address other than 000 changes no register and leaves `rxd_o` high throughout.
- R12: A write to index 3 through 14 is dropped, and a read of such an index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial control clock |
| swdat_i | input | 1 | Transmit data, or write command bits during a transaction |
| rx_light_i | input | 1 | Receiver pulse, high while light is detected |
| led_o | output | 1 | LED drive, high turns the LED on |
| rxd_o | output | 1 | Receive data (low pulse), or read response during a transaction |
| led_dis_o | output | 1 | High while a transaction holds the LED off |
| rx_dis_o | output | 1 | High while the receive detector is blocked for a response |
| shutdown_o | output | 1 | High while register 0 selects shutdown |
| mir_o | output | 1 | High when register 1 selects the fast rate |
| power_o | output | 2 | Optical power level from register 2 |

## Verification
The arming count is tried three ways: with 29 low edges followed by a high edge, with a full run of 30, and with a probe edge after each. This separates an off-by-one threshold from a count that fails to restart. Commands are sent with distinct bit patterns in every field (mixed data bytes, non-zero addresses, indexes 0 to 2, 5 and 1111). A wrong bit position or address decode therefore shows up as a wrong register value or a response that is not released. Reads are ended both directly and after an extra low edge before the marker, which tells a marker-driven end apart from one that counts bits.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 3;
  localparam logic [3:0] EXT_IDX = 4'hF;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_BYTE, ST_RESP} stc_state_e;

  function automatic logic [BYTE_W-1:0] reg_reset(input int i);
    return (i == 2) ? 8'hC0 : 8'h00;
  endfunction
endpackage

// File: rtl/stc_arm.sv
module stc_arm #(
  parameter int ARM_EDGES = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic swdat_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(ARM_EDGES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_o <= 1'b0;
    end else if (!armed_o && rise_i) begin
      if (swdat_i)                              cnt_q   <= '0;
      else if (cnt_q == CNT_W'(ARM_EDGES - 1))  armed_o <= 1'b1;
      else                                      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stc_frame.sv
module stc_frame
  import stc_pkg::*;
#(
  parameter logic [2:0] DEV_ADDR   = 3'b000,
  parameter int         RESP_FIRST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              rise_i,
  input  logic              swdat_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              in_txn_o,
  output logic              resp_o,
  output logic              srdat_o,
  output logic              wr_stb_o,
  output logic [3:0]        idx_o,
  output logic              ext_o,
  output logic [BYTE_W-1:0] eidx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int RESP_LAST = RESP_FIRST + BYTE_W - 1;
  localparam int RC_MAX    = RESP_LAST + 1;
  localparam int RC_W      = $clog2(RC_MAX + 1);

  stc_state_e        st_q;
  logic [1:0]        byte_no_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-2:0] sh_q;
  logic [2:0]        addr_q;
  logic [3:0]        idx_q;
  logic              wr_q;
  logic [BYTE_W-1:0] eidx_q;
  logic [RC_W-1:0]   rc_q;
  logic              prev_q;

  logic              step, last_bit, ext_q, match;
  logic [BYTE_W-1:0] byte_w;
  logic [2:0]        rbit;

  assign step     = rise_i && armed_i;
  assign last_bit = (st_q == ST_BYTE) && (bit_q == 3'd7);
  assign byte_w   = {swdat_i, sh_q};
  assign ext_q    = (idx_q == EXT_IDX);
  assign match    = (addr_q == DEV_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      byte_no_q <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      idx_q     <= '0;
      wr_q      <= 1'b0;
      eidx_q    <= '0;
      rc_q      <= '0;
      prev_q    <= 1'b0;
    end else if (step) begin
      unique case (st_q)
        ST_IDLE: begin
          st_q      <= ST_GAP;
          byte_no_q <= '0;
        end
        ST_GAP: begin  // start cycle before each byte
          st_q  <= ST_BYTE;
          bit_q <= '0;
        end
        ST_BYTE: begin
          sh_q <= {swdat_i, sh_q[BYTE_W-2:1]};
          if (bit_q != 3'd7) begin
            bit_q <= bit_q + 1'b1;
          end else begin
            unique case (byte_no_q)
              2'd0: begin
                addr_q <= byte_w[2:0];
                idx_q  <= byte_w[6:3];
                wr_q   <= byte_w[7];
                if (byte_w[7] || byte_w[6:3] == EXT_IDX) begin
                  st_q      <= ST_GAP;
                  byte_no_q <= 2'd1;
                end else begin
                  st_q   <= ST_RESP;
                  rc_q   <= '0;
                  prev_q <= 1'b0;
                end
              end
              2'd1: begin
                if (ext_q) begin
                  eidx_q <= byte_w;
                  if (wr_q) begin
                    st_q      <= ST_GAP;
                    byte_no_q <= 2'd2;
                  end else begin
                    st_q   <= ST_RESP;
                    rc_q   <= '0;
                    prev_q <= 1'b0;
                  end
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_RESP: begin  // end marker: high then low
          if (prev_q && !swdat_i) begin
            st_q <= ST_IDLE;
          end else begin
            if (rc_q != RC_W'(RC_MAX)) rc_q <= rc_q + 1'b1;
            prev_q <= swdat_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_stb_o = step && last_bit && wr_q && match &&
                    ((byte_no_q == 2'd1 && !ext_q) || byte_no_q == 2'd2);
  assign wr_data_o = byte_w;
  assign idx_o     = idx_q;
  assign ext_o     = ext_q;
  assign eidx_o    = eidx_q;
  assign in_txn_o  = (st_q != ST_IDLE);
  assign resp_o    = (st_q == ST_RESP) && match;
  assign rbit      = 3'(rc_q - RC_W'(RESP_FIRST));
  assign srdat_o   = (resp_o && rc_q >= RC_W'(RESP_FIRST) && rc_q <= RC_W'(RESP_LAST))
                     ? rd_data_i[rbit] : 1'b1;
endmodule

// File: rtl/stc_regs.sv
module stc_regs
  import stc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFR_EIDX  = 8'h00,
  parameter logic [BYTE_W-1:0] MFR_ID    = 8'h01,
  parameter logic [BYTE_W-1:0] PROD_EIDX = 8'h01,
  parameter logic [BYTE_W-1:0] PROD_ID   = 8'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [3:0]        idx_i,
  input  logic              ext_i,
  input  logic [BYTE_W-1:0] eidx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [2:0]        io_ctl_o,
  output logic              mir_o,
  output logic [1:0]        power_o
);
  logic [BYTE_W-1:0] r_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) r_q[i] <= reg_reset(i);
    end else if (wr_stb_i && !ext_i) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx_i == 4'(i)) r_q[i] <= data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (ext_i) begin
      if (eidx_i == MFR_EIDX)       rd_data_o = MFR_ID;
      else if (eidx_i == PROD_EIDX) rd_data_o = PROD_ID;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx_i == 4'(i)) rd_data_o = r_q[i];
    end
  end

  assign io_ctl_o = r_q[0][2:0];
  assign mir_o    = r_q[1][0];
  assign power_o  = r_q[2][7:6];
endmodule

// File: rtl/stc_iomux.sv
module stc_iomux (
  input  logic [2:0] io_ctl_i,
  input  logic       in_txn_i,
  input  logic       srdat_i,
  input  logic       txd_i,
  input  logic       rx_light_i,
  output logic       led_o,
  output logic       rxd_o
);
  logic normal, rx_en, tx_en;
  assign normal = io_ctl_i[0];
  assign rx_en  = io_ctl_i[1];
  assign tx_en  = io_ctl_i[2];

  assign led_o = !in_txn_i && normal && tx_en && txd_i;
  assign rxd_o = in_txn_i ? srdat_i : !(normal && rx_en && rx_light_i);
endmodule

// File: rtl/stc_slave.sv
module stc_slave
  import stc_pkg::*;
#(
  parameter int         ARM_EDGES = 30,
  parameter logic [2:0] DEV_ADDR  = 3'b000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       swdat_i,
  input  logic       rx_light_i,
  output logic       led_o,
  output logic       rxd_o,
  output logic       led_dis_o,
  output logic       rx_dis_o,
  output logic       shutdown_o,
  output logic       mir_o,
  output logic [1:0] power_o
);
  logic sclk_q, rise, armed, in_txn, srdat, wr_stb, ext;
  logic [3:0]        idx;
  logic [BYTE_W-1:0] eidx, wr_data, rd_data;
  logic [2:0]        io_ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end
  assign rise = sclk_i && !sclk_q;

  stc_arm #(.ARM_EDGES(ARM_EDGES)) i_arm (
    .clk_i, .rst_ni, .rise_i(rise), .swdat_i, .armed_o(armed)
  );

  stc_frame #(.DEV_ADDR(DEV_ADDR)) i_frame (
    .clk_i, .rst_ni, .armed_i(armed), .rise_i(rise), .swdat_i,
    .rd_data_i(rd_data), .in_txn_o(in_txn), .resp_o(rx_dis_o),
    .srdat_o(srdat), .wr_stb_o(wr_stb), .idx_o(idx), .ext_o(ext),
    .eidx_o(eidx), .wr_data_o(wr_data)
  );

  stc_regs i_regs (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .idx_i(idx), .ext_i(ext),
    .eidx_i(eidx), .data_i(wr_data), .rd_data_o(rd_data),
    .io_ctl_o(io_ctl), .mir_o, .power_o
  );

  stc_iomux i_iomux (
    .io_ctl_i(io_ctl), .in_txn_i(in_txn), .srdat_i(srdat), .txd_i(swdat_i),
    .rx_light_i, .led_o, .rxd_o
  );

  assign led_dis_o  = in_txn;
  assign shutdown_o = !io_ctl[0];
endmodule

// File: rtl/stc_slave_chk.sv
module stc_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_i,
  input logic       swdat_i,
  input logic       rx_light_i,
  input logic       led_o,
  input logic       rxd_o,
  input logic       led_dis_o,
  input logic       rx_dis_o,
  input logic       shutdown_o,
  input logic       mir_o,
  input logic [1:0] power_o
);
  assert_led_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_dis_o |-> !led_o);

  assert_pend_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_dis_o) |-> ($past(sclk_i) && !$past(sclk_i, 2)));

  assert_rxdis_in_txn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_o |-> led_dis_o);

  assert_resp_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_dis_o) |-> !led_dis_o);

  assert_sleep_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !led_dis_o) |-> (!led_o && rxd_o));

  assert_cfg_on_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(power_o) || !$stable(mir_o) || !$stable(shutdown_o)) |-> $fell(led_dis_o));
endmodule

bind stc_slave stc_slave_chk i_chk (.*);

// File: tb/test_stc_slave.sv
module test_stc_slave;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 1'b0, swdat_i = 1'b0, rx_light_i = 1'b0;
  logic led_o, rxd_o, led_dis_o, rx_dis_o, shutdown_o, mir_o;
  logic [1:0] power_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic rx_s, ldis_s, rdis_s;

  always #4 clk_i = ~clk_i;

  stc_slave i_stc_slave (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_edge(input logic d);
    @(negedge clk_i) swdat_i = d;
    repeat (3) @(negedge clk_i);
    sclk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rx_s = rxd_o; ldis_s = led_dis_o; rdis_s = rx_dis_o;
    sclk_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_byte(input logic [7:0] b);
    clk_edge(1'b0);
    for (int k = 0; k < 8; k++) clk_edge(b[k]);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [3:0] idx, input logic [7:0] d);
    clk_edge(1'b1);
    check("R2 pending edge sets led_dis", {7'd0, ldis_s}, 8'd1);
    send_byte({1'b1, idx, a});
    send_byte(d);
    check("R4 led_dis released after write", {7'd0, ldis_s}, 8'd0);
  endtask

  task automatic do_ext_write(input logic [7:0] eidx, input logic [7:0] d);
    clk_edge(1'b0);
    send_byte({1'b1, 4'hF, 3'b000});
    send_byte(eidx);
    send_byte(d);
    check("R5 led_dis released after ext write", {7'd0, ldis_s}, 8'd0);
  endtask

  task automatic do_read(input logic [2:0] a, input logic [3:0] idx, input bit ext,
                         input logic [7:0] eidx, input bit extra, input bit want_dis,
                         output logic [7:0] val);
    bit dis_ok = 1'b1;
    clk_edge(1'b0);
    send_byte({1'b0, ext ? 4'hF : idx, a});
    if (ext) send_byte(eidx);
    clk_edge(1'b0);  // turnaround
    clk_edge(1'b0);  // start cycle
    for (int k = 0; k < 8; k++) begin
      clk_edge(1'b0);
      val[k] = rx_s;
      if (rdis_s !== want_dis) dis_ok = 1'b0;
    end
    check("R6 rx_dis over response bits", {7'd0, dis_ok}, 8'd1);
    if (extra) begin
      clk_edge(1'b0);
      check("R7 extra low edge keeps txn", {7'd0, ldis_s}, 8'd1);
    end
    clk_edge(1'b1);
    check("R7 marker high keeps txn", {7'd0, ldis_s}, 8'd1);
    clk_edge(1'b0);
    check("R7 marker low ends txn", {7'd0, ldis_s}, 8'd0);
  endtask

  task automatic t_reset;
    @(negedge clk_i) swdat_i = 1'b1; rx_light_i = 1'b1;
    @(negedge clk_i);
    check("R8 shutdown_o", {7'd0, shutdown_o}, 8'd1);
    check("R8 mir_o", {7'd0, mir_o}, 8'd0);
    check("R8 power_o", {6'd0, power_o}, 8'd3);
    check("R9 led off in shutdown", {7'd0, led_o}, 8'd0);
    check("R9 rxd high in shutdown", {7'd0, rxd_o}, 8'd1);
    check("R8 led_dis idle", {7'd0, led_dis_o}, 8'd0);
    rx_light_i = 1'b0;
  endtask

  task automatic t_arm;
    for (int i = 0; i < 29; i++) clk_edge(1'b0);
    clk_edge(1'b1);
    check("R1 not armed after 29 low edges", {7'd0, ldis_s}, 8'd0);
    for (int i = 0; i < 30; i++) clk_edge(1'b0);
    check("R1 arming edge is not pending", {7'd0, ldis_s}, 8'd0);
  endtask

  task automatic t_reset_reads;
    logic [7:0] v;
    do_read(3'b000, 4'd0, 1'b0, 8'h00, 1'b0, 1'b1, v); check("R8 reg0 reset", v, 8'h00);
    do_read(3'b000, 4'd1, 1'b0, 8'h00, 1'b0, 1'b1, v); check("R8 reg1 reset", v, 8'h00);
    do_read(3'b000, 4'd2, 1'b0, 8'h00, 1'b1, 1'b1, v); check("R8 reg2 reset", v, 8'hC0);
  endtask

  task automatic t_cfg_writes;
    logic [7:0] v;
    do_write(3'b000, 4'd1, 8'h01);
    check("R10 mir_o after write", {7'd0, mir_o}, 8'd1);
    do_write(3'b000, 4'd2, 8'h5A);
    check("R10 power_o after write", {6'd0, power_o}, 8'd1);
    do_read(3'b000, 4'd2, 1'b0, 8'h00, 1'b0, 1'b1, v);
    check("R3 reg2 readback LSB first", v, 8'h5A);
    do_read(3'b000, 4'd1, 1'b0, 8'h00, 1'b0, 1'b1, v);
    check("R4 reg1 readback", v, 8'h01);
  endtask

  task automatic t_io_paths;
    do_write(3'b000, 4'd0, 8'h07);
    check("R9 shutdown_o cleared", {7'd0, shutdown_o}, 8'd0);
    @(negedge clk_i) swdat_i = 1'b1; rx_light_i = 1'b1;
    @(negedge clk_i);
    check("R9 led follows txd", {7'd0, led_o}, 8'd1);
    check("R9 rxd low on light", {7'd0, rxd_o}, 8'd0);
    swdat_i = 1'b0; rx_light_i = 1'b0;
    @(negedge clk_i);
    check("R9 led off when txd low", {7'd0, led_o}, 8'd0);
    check("R9 rxd high no light", {7'd0, rxd_o}, 8'd1);
    do_write(3'b000, 4'd0, 8'h01);
    @(negedge clk_i) swdat_i = 1'b1; rx_light_i = 1'b1;
    @(negedge clk_i);
    check("R9 tx disabled gates led", {7'd0, led_o}, 8'd0);
    check("R9 rx disabled gates rxd", {7'd0, rxd_o}, 8'd1);
    rx_light_i = 1'b0;
  endtask

  task automatic t_ext;
    logic [7:0] v;
    do_read(3'b000, 4'd0, 1'b1, 8'h00, 1'b0, 1'b1, v); check("R5 ext 0x00 id", v, 8'h01);
    do_read(3'b000, 4'd0, 1'b1, 8'h01, 1'b0, 1'b1, v); check("R5 ext 0x01 id", v, 8'h41);
    do_read(3'b000, 4'd0, 1'b1, 8'h05, 1'b0, 1'b1, v); check("R5 ext other", v, 8'h00);
    do_ext_write(8'h00, 8'h55);
    do_read(3'b000, 4'd0, 1'b1, 8'h00, 1'b0, 1'b1, v); check("R5 ext write dropped", v, 8'h01);
    do_read(3'b000, 4'd0, 1'b0, 8'h00, 1'b0, 1'b1, v); check("R5 reg0 untouched", v, 8'h01);
  endtask

  task automatic t_foreign_addr;
    logic [7:0] v;
    do_write(3'b011, 4'd1, 8'h00);
    check("R11 mir_o kept", {7'd0, mir_o}, 8'd1);
    do_write(3'b100, 4'd2, 8'h00);
    check("R11 power_o kept", {6'd0, power_o}, 8'd1);
    do_read(3'b011, 4'd2, 1'b0, 8'h00, 1'b0, 1'b0, v);
    check("R11 rxd released", v, 8'hFF);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    do_write(3'b000, 4'd5, 8'hAA);
    do_read(3'b000, 4'd5, 1'b0, 8'h00, 1'b0, 1'b1, v); check("R12 unimpl read", v, 8'h00);
    do_read(3'b000, 4'd2, 1'b0, 8'h00, 1'b1, 1'b1, v); check("R12 reg2 unchanged", v, 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_arm();
    t_reset_reads();
    t_cfg_writes();
    t_io_paths();
    t_ext();
    t_foreign_addr();
    t_unimpl();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule